// File: doc/BRIEF.md
# Load-Use Interlock and Operand Bypass Control

This block decides, every cycle, whether the instruction sitting in the execute stage of a three-stage pipeline may proceed. Stage 2 executes and forms addresses, and stage 3 accesses memory. A load's data therefore exists only in stage 3. The block compares the execute-stage source indices against the destination of the stage-3 instruction. It then either raises an interlock or selects a bypass path for each operand. Register contents and arithmetic are outside it.

A producer is "late" when its result appears only in stage 3. Loads are always late. The single-cycle multiplier is late when `LATE_MUL` is set. A late result cannot feed a stage-2 consumer, so one bubble is needed. There is one exception: the store-data operand (source 2 of a store) is consumed in stage 3, so it takes the late value over a bypass and needs no stall. A store's base address is consumed in stage 2 and still interlocks.

While the interlock is active, the PC, stage 1 and stage 2 hold, and stage 3 is loaded with a no-op. In the following cycle the block knows that stage 3 holds that no-op, and it ignores the stage-3 producer fields. The stall therefore never lasts more than one cycle.

Top module: `lu_interlock`

Encodings used throughout:
- Instruction class (`s2_cls`, `s3_cls`): 0 = other/ALU, 1 = load, 2 = store, 3 = multiply.
- Forward select (`fwd_rs1`, `fwd_rs2`): 0 = register file, 1 = stage-3 execute result, 2 = stage-3 late (memory or multiplier) data.

## Requirements
- R1: `stall` and `bubble` are 1 in the same cycle when all of these hold: stage 2 is valid and reads source 1, stage 3 is a writing load, and its nonzero destination equals source 1.
- R2: In the same situation on source 2, with stage 2 not a store (class other than 2), `stall` and `bubble` are 1.
- R3: When stage 2 is a store (class 2) and its source 2 matches a writing load's nonzero destination, there is no stall. `fwd_rs2` is 2, provided source 1 does not also match.
- R4: When stage 2 is a store and its source 1 (base address) matches a writing load's nonzero destination, `stall` and `bubble` are 1.
- R5: A stage-3 destination of 0 never causes a stall and never selects a bypass (both selects 0).
- R6: An operand whose use flag is 0 causes no stall and has select 0, even if its index equals the stage-3 destination.
- R7: A match against a writing stage-3 instruction of class 0 (not late) gives select 1 on that operand and no stall.
- R8: With `LATE_MUL`=1, a stage-3 multiply (class 3) is late: a dependent non-store-data use stalls, and a store-data use gets select 2.
- R9: With `s3_wen`=0, or with no index match, there is no stall and both selects are 0.
- R10: In the cycle after a stall, the stage-3 fields are ignored: no stall, and both selects are 0.
- R11: With `s2_valid`=0 there is no stall, both selects are 0, and `rs2_late` is 0.
- R12: `rs2_late` is 1 exactly when stage 2 is valid and is a store (class 2). While `rst_n` is low, no cycle is treated as following a stall, so a hazard is flagged in every reset cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| s2_valid | input | 1 | Stage 2 holds a real instruction |
| s2_rs1 | input | IDX_W | Stage-2 source 1 index |
| s2_rs1_use | input | 1 | Stage 2 reads source 1 |
| s2_rs2 | input | IDX_W | Stage-2 source 2 index |
| s2_rs2_use | input | 1 | Stage 2 reads source 2 |
| s2_cls | input | 2 | Stage-2 instruction class |
| s3_rd | input | IDX_W | Stage-3 destination index |
| s3_wen | input | 1 | Stage 3 writes its destination |
| s3_cls | input | 2 | Stage-3 instruction class |
| stall | output | 1 | Hold PC, stage 1 and stage 2 |
| bubble | output | 1 | Load a no-op into stage 3 |
| fwd_rs1 | output | 2 | Source 1 bypass select |
| fwd_rs2 | output | 2 | Source 2 bypass select |
| rs2_late | output | 1 | Source 2 of stage 2 is consumed in stage 3 |

## Verification
The hardest situation to reach is the interplay between back-to-back hazards and the one-cycle masking after a stall. A vector that would stall must be checked both cold and directly after another stall, where the correct answer flips to "no stall". The bench uses a two-bit index configuration and walks every combination of indices, use flags, classes, write enable and valid in nested order. Consecutive vectors therefore land both right after stalls and right after clean cycles. A reference model tracks the previous expected stall, so both cases are predicted arithmetically.

// File: rtl/lu_pkg.sv
package lu_pkg;
   typedef enum logic [1:0] {
      CLS_OTHER = 2'd0,
      CLS_LOAD  = 2'd1,
      CLS_STORE = 2'd2,
      CLS_MUL   = 2'd3
   } iclass_t;

   typedef enum logic [1:0] {
      SEL_RF   = 2'd0,
      SEL_EXEC = 2'd1,
      SEL_LATE = 2'd2
   } fwd_sel_t;
endpackage

// File: rtl/lu_producer.sv
// Classifies the stage-3 instruction as a producer: whether it writes a
// real register and whether its value only appears in stage 3.
module lu_producer #(
   parameter int IDX_W    = 5,
   parameter bit LATE_MUL = 1'b1
) (
   input  logic [IDX_W-1:0] rd,
   input  logic             wen,
   input  logic [1:0]       cls,
   input  logic             masked,
   output logic             wr_o,
   output logic             late_o
);
   import lu_pkg::*;

   assign wr_o = wen && !masked && (rd != '0);

   generate
      if (LATE_MUL) begin : g_mul_late
         assign late_o = (cls == CLS_LOAD) || (cls == CLS_MUL);
      end else begin : g_mul_early
         assign late_o = (cls == CLS_LOAD);
      end
   endgenerate
endmodule

// File: rtl/lu_operand.sv
// One source operand: match against the producer, hazard and select.
module lu_operand #(
   parameter int IDX_W = 5
) (
   input  logic [IDX_W-1:0] src,
   input  logic             use_i,
   input  logic             late_use,
   input  logic [IDX_W-1:0] p_rd,
   input  logic             p_wr,
   input  logic             p_late,
   output logic             hz_o,
   output logic [1:0]       sel_o
);
   import lu_pkg::*;

   logic hit;

   assign hit  = use_i && p_wr && (src == p_rd);
   assign hz_o = hit && p_late && !late_use;

   always_comb begin
      sel_o = SEL_RF;
      if (hit) begin
         if (!p_late)
            sel_o = SEL_EXEC;
         else if (late_use)
            sel_o = SEL_LATE;
      end
   end
endmodule

// File: rtl/lu_interlock.sv
module lu_interlock #(
   parameter int IDX_W           = 5,
   parameter bit LATE_MUL        = 1'b1,
   parameter bit STORE_DATA_LATE = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             s2_valid,
   input  logic [IDX_W-1:0] s2_rs1,
   input  logic             s2_rs1_use,
   input  logic [IDX_W-1:0] s2_rs2,
   input  logic             s2_rs2_use,
   input  logic [1:0]       s2_cls,
   input  logic [IDX_W-1:0] s3_rd,
   input  logic             s3_wen,
   input  logic [1:0]       s3_cls,
   output logic             stall,
   output logic             bubble,
   output logic [1:0]       fwd_rs1,
   output logic [1:0]       fwd_rs2,
   output logic             rs2_late
);
   import lu_pkg::*;

   localparam int NUM_SRC = 2;

   if (IDX_W < 1 || IDX_W > 6) begin : g_bad_idx_w
      $error("lu_interlock: IDX_W must lie in 1..6");
   end

   logic             mask_q;
   logic             p_wr, p_late;
   logic [IDX_W-1:0] src_a  [NUM_SRC];
   logic             use_a  [NUM_SRC];
   logic             late_a [NUM_SRC];
   logic             hz_a   [NUM_SRC];
   logic [1:0]       sel_a  [NUM_SRC];
   logic             is_store;
   logic             hz_any;

   assign is_store = (s2_cls == CLS_STORE);

   assign src_a[0]  = s2_rs1;
   assign src_a[1]  = s2_rs2;
   assign use_a[0]  = s2_rs1_use;
   assign use_a[1]  = s2_rs2_use;
   assign late_a[0] = 1'b0;

   generate
      if (STORE_DATA_LATE) begin : g_sd_late
         assign late_a[1] = is_store;
      end else begin : g_sd_early
         assign late_a[1] = 1'b0;
      end
   endgenerate

   lu_producer #(.IDX_W(IDX_W), .LATE_MUL(LATE_MUL)) u_prod (
      .rd     (s3_rd),
      .wen    (s3_wen),
      .cls    (s3_cls),
      .masked (mask_q),
      .wr_o   (p_wr),
      .late_o (p_late)
   );

   for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
      lu_operand #(.IDX_W(IDX_W)) u_opnd (
         .src      (src_a[g]),
         .use_i    (use_a[g]),
         .late_use (late_a[g]),
         .p_rd     (s3_rd),
         .p_wr     (p_wr),
         .p_late   (p_late),
         .hz_o     (hz_a[g]),
         .sel_o    (sel_a[g])
      );
   end

   assign hz_any   = hz_a[0] || hz_a[1];
   assign stall    = s2_valid && hz_any;
   assign bubble   = s2_valid && hz_any;
   assign fwd_rs1  = s2_valid ? sel_a[0] : SEL_RF;
   assign fwd_rs2  = s2_valid ? sel_a[1] : SEL_RF;
   assign rs2_late = s2_valid && late_a[1];

   // Stage 3 holds the injected no-op in the cycle after a stall.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mask_q <= 1'b0;
      else        mask_q <= stall;
   end
endmodule

// File: rtl/lu_interlock_chk.sv
module lu_interlock_chk #(
   parameter int IDX_W = 5
) (
   input logic             clk,
   input logic             rst_n,
   input logic             s2_valid,
   input logic [IDX_W-1:0] s2_rs1,
   input logic             s2_rs1_use,
   input logic [IDX_W-1:0] s2_rs2,
   input logic             s2_rs2_use,
   input logic [1:0]       s2_cls,
   input logic [IDX_W-1:0] s3_rd,
   input logic             s3_wen,
   input logic [1:0]       s3_cls,
   input logic             stall,
   input logic [1:0]       fwd_rs1,
   input logic [1:0]       fwd_rs2,
   input logic             rs2_late,
   input logic             mask_q
);
   logic out_of_rst;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) out_of_rst <= 1'b0;
      else        out_of_rst <= 1'b1;
   end

   assert_load_rs1_stall_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (s2_valid && s2_rs1_use && s3_wen && s3_cls == 2'd1 && s3_rd != '0
       && s2_rs1 == s3_rd && !mask_q) |-> stall);

   assert_store_data_bypass_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (s2_valid && s2_cls == 2'd2 && s2_rs2_use && !s2_rs1_use && s3_wen
       && s3_cls == 2'd1 && s3_rd != '0 && s2_rs2 == s3_rd && !mask_q)
      |-> (!stall && fwd_rs2 == 2'd2));

   assert_zero_dest_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (s3_rd == '0) |-> (!stall && fwd_rs1 == 2'd0 && fwd_rs2 == 2'd0));

   assert_unused_rs1_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !s2_rs1_use |-> (fwd_rs1 == 2'd0));

   assert_single_bubble_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (out_of_rst && $past(stall)) |-> (!stall && fwd_rs1 == 2'd0 && fwd_rs2 == 2'd0));

   assert_idle_stage_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !s2_valid |-> (!stall && fwd_rs1 == 2'd0 && fwd_rs2 == 2'd0 && !rs2_late));
endmodule

bind lu_interlock lu_interlock_chk #(.IDX_W(IDX_W)) chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .s2_valid   (s2_valid),
   .s2_rs1     (s2_rs1),
   .s2_rs1_use (s2_rs1_use),
   .s2_rs2     (s2_rs2),
   .s2_rs2_use (s2_rs2_use),
   .s2_cls     (s2_cls),
   .s3_rd      (s3_rd),
   .s3_wen     (s3_wen),
   .s3_cls     (s3_cls),
   .stall      (stall),
   .fwd_rs1    (fwd_rs1),
   .fwd_rs2    (fwd_rs2),
   .rs2_late   (rs2_late),
   .mask_q     (mask_q)
);

// File: tb/lu_interlock_test.sv
`timescale 1ns/1ps
module lu_interlock_test;
   localparam int W = 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic v = 1'b0, e1 = 1'b0, e2 = 1'b0, w3 = 1'b0;
   logic [W-1:0] a1 = '0, a2 = '0, d3 = '0;
   logic [1:0] k2 = '0, k3 = '0;
   logic stall, bubble, rs2_late;
   logic [1:0] fwd_rs1, fwd_rs2;

   int vectors = 0;
   int fails = 0;
   bit prev_stall = 1'b0;

   always #2 clk = ~clk;

   lu_interlock #(.IDX_W(W), .LATE_MUL(1'b1), .STORE_DATA_LATE(1'b1)) uut (
      .clk(clk), .rst_n(rst_n),
      .s2_valid(v), .s2_rs1(a1), .s2_rs1_use(e1), .s2_rs2(a2), .s2_rs2_use(e2),
      .s2_cls(k2), .s3_rd(d3), .s3_wen(w3), .s3_cls(k3),
      .stall(stall), .bubble(bubble), .fwd_rs1(fwd_rs1), .fwd_rs2(fwd_rs2),
      .rs2_late(rs2_late)
   );

   task automatic cmp(string tag, string what, int act, int exp);
      vectors++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
      end
   endtask

   // Reference from the requirements; classes: 1 load, 2 store, 3 multiply.
   task automatic check(string tag);
      bit late_p, wr, m1, m2, sd, xs;
      int f1, f2;
      late_p = (k3 == 2'd1) || (k3 == 2'd3);
      wr = w3 && !prev_stall && (d3 != 0);
      m1 = e1 && wr && (a1 == d3);
      m2 = e2 && wr && (a2 == d3);
      sd = (k2 == 2'd2);
      xs = v && ((m1 && late_p) || (m2 && late_p && !sd));
      f1 = (v && m1) ? (late_p ? 0 : 1) : 0;
      f2 = (v && m2) ? (late_p ? (sd ? 2 : 0) : 1) : 0;
      #1;
      cmp(tag, "stall", int'(stall), int'(xs));
      cmp(tag, "bubble", int'(bubble), int'(xs));
      cmp(tag, "fwd_rs1", int'(fwd_rs1), f1);
      cmp(tag, "fwd_rs2", int'(fwd_rs2), f2);
      cmp(tag, "rs2_late", int'(rs2_late), int'(v && sd));
      prev_stall = rst_n ? xs : 1'b0;
   endtask

   task automatic put(bit vv, int r1, bit u1, int r2, bit u2, int c2,
                      int rd, bit we, int c3);
      @(negedge clk);
      v = vv; a1 = W'(r1); e1 = u1; a2 = W'(r2); e2 = u2; k2 = 2'(c2);
      d3 = W'(rd); w3 = we; k3 = 2'(c3);
   endtask

   function automatic string classify();
      if (!v) return "R11";
      if (prev_stall) return "R10";
      if (d3 == 0) return "R5";
      if (!e1 && !e2) return "R6";
      if (!w3) return "R9";
      if (k3 == 2'd0 || k3 == 2'd2) return "R7";
      if (k3 == 2'd3) return "R8";
      if (k2 == 2'd2) return (e1 && a1 == d3) ? "R4" : "R3";
      return (e1 && a1 == d3) ? "R1" : "R2";
   endfunction

   initial begin
      // R12: during reset every hazard cycle stalls
      put(1, 1, 1, 0, 0, 0, 1, 1, 1); check("R12_rst_a");
      put(1, 1, 1, 0, 0, 0, 1, 1, 1); check("R12_rst_b");
      put(1, 0, 0, 0, 0, 2, 0, 0, 0); check("R12_rs2_late");
      @(negedge clk); rst_n = 1'b1;
      put(0, 0, 0, 0, 0, 0, 0, 0, 0); check("R11_idle");
      put(1, 2, 1, 0, 0, 0, 2, 1, 1); check("R1_load_rs1");
      put(1, 2, 1, 0, 0, 0, 2, 1, 1); check("R10_after_stall");
      put(1, 0, 0, 3, 1, 0, 3, 1, 1); check("R2_load_rs2");
      put(1, 0, 0, 0, 0, 0, 0, 0, 0); check("R9_quiet");
      put(1, 0, 0, 1, 1, 2, 1, 1, 1); check("R3_store_data");
      put(1, 1, 1, 2, 1, 2, 1, 1, 1); check("R4_store_base");
      put(1, 0, 0, 0, 0, 0, 0, 0, 0); check("R9_quiet2");
      put(1, 0, 1, 0, 1, 0, 0, 1, 1); check("R5_dest_zero");
      put(1, 3, 0, 3, 0, 0, 3, 1, 1); check("R6_no_use");
      put(1, 1, 1, 1, 1, 0, 1, 1, 0); check("R7_exec_fwd");
      put(1, 2, 1, 0, 0, 0, 2, 1, 3); check("R8_mul_stall");
      put(1, 0, 0, 0, 0, 0, 0, 0, 0); check("R9_quiet3");
      put(1, 0, 0, 2, 1, 2, 2, 1, 3); check("R8_mul_store_data");
      put(1, 1, 1, 2, 1, 0, 3, 1, 1); check("R9_no_match");
      // exhaustive sweep over the two-bit configuration
      for (int iv = 0; iv < 2; iv++)
       for (int ic2 = 0; ic2 < 4; ic2++)
        for (int ic3 = 0; ic3 < 4; ic3++)
         for (int iw = 0; iw < 2; iw++)
          for (int iu = 0; iu < 4; iu++)
           for (int ir1 = 0; ir1 < 4; ir1++)
            for (int ir2 = 0; ir2 < 4; ir2++)
             for (int ird = 0; ird < 4; ird++) begin
                put(iv[0], ir1, iu[0], ir2, iu[1], ic2, ird, iw[0], ic3);
                check(classify());
             end
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end

   initial begin
      #(4 * 150000);
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end
endmodule